// File: doc/BRIEF.md
# UART Receive Status Flag Unit

This block keeps the receive-side status flags of a UART and produces its three event trigger pulses. The receive datapath hands it one strobe per completed character, together with the character's data and its noise, framing and parity indications. The unit decides whether the character can enter the single-entry receive buffer or whether it must be discarded as an overrun. When it is accepted, the data-ready flag, the error flags and two address-match flags are raised in the same cycle. Flags are cleared through a small register write port or, for data-ready, by a buffer read strobe.

A separate path watches the raw serial input through a synchronizer and raises an edge flag on a falling edge while the receiver is enabled. Three trigger outputs go to other blocks on the chip: one for the end of each transmitted word, lasting one bit period; one for each word written into the receive buffer; and one for line idle. The last two each last one oversampling period. Baud generation, sampling, shifting and any FIFO sit outside this unit.

Top module: `uart_rx_flags`

## Requirements
- R1: Flag vector bit positions: 0 data-ready, 1 overrun, 2 noise, 3 framing, 4 parity, 5 match-1, 6 match-2, 7 RX-edge. After reset all flags, the data buffer and all three triggers are 0.
- R2: A character strobe is accepted when data-ready is 0 or a buffer read is given in the same cycle. At the next clock edge the buffer holds the character and data-ready is 1. Noise, framing and parity are set at that same edge from the strobe's indications.
- R3: A character strobe while data-ready is 1 and no read is given sets overrun. The buffer keeps its old value, and noise, framing and parity are not set by that character.
- R4: An accepted character equal to match register 1 sets match-1, and one equal to match register 2 sets match-2, at the same edge as data-ready. Both can set together. An overrun character sets neither.
- R5: A buffer read clears data-ready at the next edge unless a character is accepted in the same cycle, in which case data-ready stays 1 and no overrun occurs.
- R6: A register write clears every flag in bits 1 to 7 whose write-data bit is 1. Write-data bits that are 0 have no effect, and bit 0 of the write data never clears data-ready.
- R7: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R8: The RX-edge flag sets at the third clock edge after the serial input is first sampled low following a high sample, if the receiver enable is 1 at that edge. A rising edge, or a falling edge while the enable is 0, leaves it at 0.
- R9: The transmit-word trigger goes high at the edge after the end-of-word strobe and goes low at the edge that samples the next bit tick. An end-of-word strobe aligned with a bit tick therefore gives exactly one bit period.
- R10: The receive-word trigger goes high at the edge after an accepted character and goes low at the edge that samples the next oversampling tick. An overrun character does not start it.
- R11: The receive-idle trigger goes high at the edge after the idle strobe and goes low at the edge that samples the next oversampling tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_valid_i | input | 1 | Character complete strobe from receive shifter |
| chr_data_i | input | DATA_W | Received character |
| chr_noise_i | input | 1 | Noise seen on this character |
| chr_frame_i | input | 1 | Framing error on this character |
| chr_parity_i | input | 1 | Parity error on this character |
| idle_det_i | input | 1 | Line idle detected strobe |
| tx_end_i | input | 1 | End of transmitted word strobe |
| rxd_i | input | 1 | Raw asynchronous serial input |
| rx_en_i | input | 1 | Receiver enable |
| match1_i | input | DATA_W | First address-match value |
| match2_i | input | DATA_W | Second address-match value |
| bit_tick_i | input | 1 | One-cycle tick per bit period |
| os_tick_i | input | 1 | One-cycle tick per oversampling period |
| reg_wr_i | input | 1 | Flag clear write strobe |
| reg_wdata_i | input | 8 | Write-1-to-clear mask, bit layout as R1 |
| buf_rd_i | input | 1 | Receive buffer read strobe |
| flags_o | output | 8 | Status flags, bit layout as R1 |
| rx_buf_o | output | DATA_W | Receive data buffer |
| trg_tx_word_o | output | 1 | Transmit-word trigger |
| trg_rx_word_o | output | 1 | Receive-word trigger |
| trg_rx_idle_o | output | 1 | Receive-idle trigger |

## Verification
The bench builds the unit with its defaults: an 8-bit data path, a two-stage input synchronizer and single-tick trigger holds. This keeps the RX-edge latency at three edges and makes each trigger width exactly the gap to the next tick, so the bench can set the tick spacing per test and predict every cycle. With byte-wide match registers, both match flags can be hit by the same value or by neighbouring values. This brings the combined, split and overrun-suppressed match cases within reach with few characters. Read-with-arrival, set-against-clear and write-zero cycles are driven deliberately, along with a sweep of characters with mixed read timing and error bits.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
   localparam int FLAG_N = 8;
   localparam int F_RDY  = 0;
   localparam int F_OVR  = 1;
   localparam int F_NSE  = 2;
   localparam int F_FRM  = 3;
   localparam int F_PAR  = 4;
   localparam int F_MT1  = 5;
   localparam int F_MT2  = 6;
   localparam int F_EDG  = 7;
   localparam logic [FLAG_N-1:0] W1C_MASK = 8'hFE;
   localparam int TRG_N   = 3;
   localparam int TRG_TXW = 0;
   localparam int TRG_RXW = 1;
   localparam int TRG_IDL = 2;
endpackage

// File: rtl/uart_rxf_flagbank.sv
module uart_rxf_flagbank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   if (N < 1 || N > 64) begin : g_bad_n
      $error("uart_rxf_flagbank: N out of range");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_r <= 1'b0;
         else if (set_i[i]) q_r <= 1'b1;
         else if (clr_i[i]) q_r <= 1'b0;
      end
      assign q_o[i] = q_r;

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]);
      // R6
      clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !q_o[i]);
   end
endmodule

// File: rtl/uart_rxf_edgesync.sv
module uart_rxf_edgesync #(
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic edge_o
);
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("uart_rxf_edgesync: SYNC_STAGES must be 2..4");
   end

   logic [SYNC_STAGES-1:0] sh_r;
   logic                   prev_r;
   logic                   cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_r   <= '1;
         prev_r <= 1'b1;
      end else begin
         sh_r   <= {sh_r[SYNC_STAGES-2:0], pin_i};
         prev_r <= cur;
      end
   end
   assign cur = sh_r[SYNC_STAGES-1];

   if (ACTIVE_FALL) begin : g_fall
      assign edge_o = prev_r & ~cur;
   end else begin : g_rise
      assign edge_o = ~prev_r & cur;
   end

   // R8
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);
endmodule

// File: rtl/uart_rxf_pulse.sv
module uart_rxf_pulse #(
   parameter int HOLD_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic tick_i,
   output logic pulse_o
);
   if (HOLD_TICKS < 1 || HOLD_TICKS > 1024) begin : g_bad_hold
      $error("uart_rxf_pulse: HOLD_TICKS must be 1..1024");
   end

   logic out_r;

   if (HOLD_TICKS == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       out_r <= 1'b0;
         else if (start_i) out_r <= 1'b1;
         else if (tick_i)  out_r <= 1'b0;
      end
      // R9
      single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_r && tick_i && !start_i) |=> !pulse_o);
   end else begin : g_count
      localparam int CW = $clog2(HOLD_TICKS);
      localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
      logic [CW-1:0] cnt_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_r <= 1'b0;
            cnt_r <= '0;
         end else if (start_i) begin
            out_r <= 1'b1;
            cnt_r <= '0;
         end else if (out_r && tick_i) begin
            if (cnt_r == LAST) out_r <= 1'b0;
            else               cnt_r <= cnt_r + 1'b1;
         end
      end
   end

   assign pulse_o = out_r;

   // R10
   start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> pulse_o);
   // R11
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !tick_i) |=> (pulse_o == $past(pulse_o)));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
   import uart_rxf_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TXW_HOLD    = 1,
   parameter int RXW_HOLD    = 1,
   parameter int IDLE_HOLD   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chr_valid_i,
   input  logic [DATA_W-1:0] chr_data_i,
   input  logic              chr_noise_i,
   input  logic              chr_frame_i,
   input  logic              chr_parity_i,
   input  logic              idle_det_i,
   input  logic              tx_end_i,
   input  logic              rxd_i,
   input  logic              rx_en_i,
   input  logic [DATA_W-1:0] match1_i,
   input  logic [DATA_W-1:0] match2_i,
   input  logic              bit_tick_i,
   input  logic              os_tick_i,
   input  logic              reg_wr_i,
   input  logic [7:0]        reg_wdata_i,
   input  logic              buf_rd_i,
   output logic [7:0]        flags_o,
   output logic [DATA_W-1:0] rx_buf_o,
   output logic              trg_tx_word_o,
   output logic              trg_rx_word_o,
   output logic              trg_rx_idle_o
);
   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_dw
      $error("uart_rx_flags: DATA_W must be 5..16");
   end
   if (FLAG_N != 8) begin : g_bad_fn
      $error("uart_rx_flags: flag vector must be 8 bits");
   end

   localparam int HOLD_TAB [TRG_N] = '{TXW_HOLD, RXW_HOLD, IDLE_HOLD};

   logic              accept;
   logic              overrun;
   logic              rx_edge;
   logic [FLAG_N-1:0] set_v;
   logic [FLAG_N-1:0] clr_v;
   logic [DATA_W-1:0] buf_r;
   logic [TRG_N-1:0]  trg_start;
   logic [TRG_N-1:0]  trg_tick;
   logic [TRG_N-1:0]  trg_out;

   assign accept  = chr_valid_i & (~flags_o[F_RDY] | buf_rd_i);
   assign overrun = chr_valid_i &  flags_o[F_RDY] & ~buf_rd_i;

   uart_rxf_edgesync #(
      .SYNC_STAGES(SYNC_STAGES),
      .ACTIVE_FALL(1'b1)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (rxd_i),
      .edge_o (rx_edge)
   );

   always_comb begin
      set_v        = '0;
      set_v[F_RDY] = accept;
      set_v[F_OVR] = overrun;
      set_v[F_NSE] = accept & chr_noise_i;
      set_v[F_FRM] = accept & chr_frame_i;
      set_v[F_PAR] = accept & chr_parity_i;
      set_v[F_MT1] = accept & (chr_data_i == match1_i);
      set_v[F_MT2] = accept & (chr_data_i == match2_i);
      set_v[F_EDG] = rx_edge & rx_en_i;
   end

   always_comb begin
      clr_v        = reg_wr_i ? (reg_wdata_i & W1C_MASK) : '0;
      clr_v[F_RDY] = buf_rd_i;
   end

   uart_rxf_flagbank #(.N(FLAG_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v),
      .clr_i (clr_v),
      .q_o   (flags_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      buf_r <= '0;
      else if (accept) buf_r <= chr_data_i;
   end
   assign rx_buf_o = buf_r;

   assign trg_start[TRG_TXW] = tx_end_i;
   assign trg_start[TRG_RXW] = accept;
   assign trg_start[TRG_IDL] = idle_det_i;
   assign trg_tick[TRG_TXW]  = bit_tick_i;
   assign trg_tick[TRG_RXW]  = os_tick_i;
   assign trg_tick[TRG_IDL]  = os_tick_i;

   for (genvar g = 0; g < TRG_N; g++) begin : g_trg
      uart_rxf_pulse #(.HOLD_TICKS(HOLD_TAB[g])) u_pulse (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (trg_start[g]),
         .tick_i  (trg_tick[g]),
         .pulse_o (trg_out[g])
      );
   end

   assign trg_tx_word_o = trg_out[TRG_TXW];
   assign trg_rx_word_o = trg_out[TRG_RXW];
   assign trg_rx_idle_o = trg_out[TRG_IDL];

   // R2
   accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid_i && (!flags_o[F_RDY] || buf_rd_i))
      |=> (flags_o[F_RDY] && rx_buf_o == $past(chr_data_i)));
   // R3
   ovr_keep_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid_i && flags_o[F_RDY] && !buf_rd_i) |=> (flags_o[F_OVR] && $stable(rx_buf_o)));
   // R3
   ovr_no_noise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid_i && flags_o[F_RDY] && !buf_rd_i && !flags_o[F_NSE]) |=> !flags_o[F_NSE]);
   // R4
   ovr_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid_i && flags_o[F_RDY] && !buf_rd_i && !flags_o[F_MT1]) |=> !flags_o[F_MT1]);
   // R8
   edge_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[F_EDG]) |-> $past(rx_en_i));
   // R6
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[F_OVR] && reg_wr_i && !reg_wdata_i[F_OVR]) |=> flags_o[F_OVR]);
   // R5
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd_i && !chr_valid_i) |=> !flags_o[F_RDY]);
endmodule

// File: tb/uart_rx_flags_bench.sv
module uart_rx_flags_bench;
   import uart_rxf_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cv = 0, cn = 0, cf = 0, cp = 0, idl = 0, txe = 0;
   logic       rxd = 1, ren = 0, bt = 0, ot = 0, wr = 0, rd = 0;
   logic [7:0] cd = 0, m1 = 0, m2 = 0, wd = 0;
   logic [7:0] flags;
   logic [7:0] rbuf;
   logic       t_tx, t_rx, t_idl;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [7:0] f;
      logic [7:0] b;
      logic [2:0] t;
      string      tag;
   } exp_t;
   exp_t q[$];

   logic [7:0] ef = 0, eb = 0;
   logic [2:0] et = 0;
   logic       a1 = 1, a2 = 1, a3 = 1;

   always #2 clk = ~clk;

   uart_rx_flags u_uart_rx_flags (
      .clk(clk), .rst_n(rst_n), .chr_valid_i(cv), .chr_data_i(cd),
      .chr_noise_i(cn), .chr_frame_i(cf), .chr_parity_i(cp),
      .idle_det_i(idl), .tx_end_i(txe), .rxd_i(rxd), .rx_en_i(ren),
      .match1_i(m1), .match2_i(m2), .bit_tick_i(bt), .os_tick_i(ot),
      .reg_wr_i(wr), .reg_wdata_i(wd), .buf_rd_i(rd),
      .flags_o(flags), .rx_buf_o(rbuf), .trg_tx_word_o(t_tx),
      .trg_rx_word_o(t_rx), .trg_rx_idle_o(t_idl)
   );

   // monitor: pops expected items after each edge settles
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (flags !== e.f || rbuf !== e.b || {t_idl, t_rx, t_tx} !== e.t) begin
               errors++;
               $display("FAIL %s: flags=%h buf=%h trg=%b expected flags=%h buf=%h trg=%b",
                        e.tag, flags, rbuf, {t_idl, t_rx, t_tx}, e.f, e.b, e.t);
            end
         end
      end
   end

   // driver: one clock edge, expected result from the requirements
   task automatic cyc(input string tag);
      logic acc, ovr;
      logic [7:0] st, cl;
      acc = cv && (!ef[F_RDY] || rd);
      ovr = cv && ef[F_RDY] && !rd;
      st = '0;
      st[F_RDY] = acc;                 // R2
      st[F_OVR] = ovr;                 // R3
      st[F_NSE] = acc && cn;
      st[F_FRM] = acc && cf;
      st[F_PAR] = acc && cp;
      st[F_MT1] = acc && (cd == m1);   // R4
      st[F_MT2] = acc && (cd == m2);
      st[F_EDG] = a3 && !a2 && ren;    // R8
      cl = wr ? (wd & 8'hFE) : 8'h00;  // R6
      cl[F_RDY] = rd;                  // R5
      @(posedge clk);
      ef = st | (ef & ~cl);            // R7
      if (acc) eb = cd;
      et[0] = txe ? 1'b1 : (bt ? 1'b0 : et[0]);  // R9
      et[1] = acc ? 1'b1 : (ot ? 1'b0 : et[1]);  // R10
      et[2] = idl ? 1'b1 : (ot ? 1'b0 : et[2]);  // R11
      a3 = a2; a2 = a1; a1 = rxd;
      q.push_back('{f: ef, b: eb, t: et, tag: tag});
      @(negedge clk);
   endtask

   task automatic quiet();
      cv = 0; cn = 0; cf = 0; cp = 0; idl = 0; txe = 0;
      bt = 0; ot = 0; wr = 0; wd = 0; rd = 0;
   endtask

   task automatic send(input logic [7:0] d, input logic n, input logic f,
                       input logic p, input logic r, input string tag);
      cv = 1; cd = d; cn = n; cf = f; cp = p; rd = r;
      cyc(tag);
      quiet();
   endtask

   task automatic wclr(input logic [7:0] m, input string tag);
      wr = 1; wd = m;
      cyc(tag);
      quiet();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      cyc("R1 reset state");

      // R2 accept with noise, R10 word trigger
      send(8'hA5, 1, 0, 0, 0, "R2 accept noise");
      cyc("R10 trigger held");
      ot = 1; cyc("R10 trigger ends on os tick"); quiet();
      rd = 1; cyc("R5 read clears ready"); quiet();
      wclr(8'h00, "R6 zero write keeps noise");
      wclr(8'h04, "R6 clear noise");

      // R3 overrun
      send(8'h11, 0, 1, 1, 0, "R2 accept frame parity");
      ot = 1; cyc("R10 tick"); quiet();
      wclr(8'h18, "R6 clear frame parity");
      send(8'h22, 1, 1, 1, 0, "R3 overrun drops char and errors");
      cyc("R10 no trigger on overrun");
      wclr(8'h01, "R6 bit0 write ignored");
      wclr(8'hFF, "R6 clear all w1c");
      send(8'h33, 0, 0, 0, 1, "R5 read with arrival");
      ot = 1; cyc("R10 tick"); quiet();

      // R4 matches
      m1 = 8'h40; m2 = 8'h40;
      send(8'h40, 0, 0, 0, 1, "R4 both match");
      wclr(8'h60, "R6 clear matches");
      m2 = 8'h41;
      send(8'h41, 0, 0, 0, 1, "R4 match2 only");
      send(8'h40, 0, 0, 0, 0, "R4 overrun sets no match");
      wclr(8'hFE, "R6 clear");
      rd = 1; cyc("R5 read"); quiet();
      ot = 1; cyc("R10 tick"); quiet();

      // R7 set beats clear
      cv = 1; cd = 8'h07; cn = 1; wr = 1; wd = 8'h04;
      cyc("R7 noise set beats clear"); quiet();
      cv = 1; cd = 8'h08; wr = 1; wd = 8'h02;
      cyc("R7 overrun set beats clear"); quiet();
      wclr(8'hFE, "R6 clear");
      rd = 1; ot = 1; cyc("R5 read"); quiet();

      // R8 edge flag
      ren = 1; rxd = 0;
      cyc("R8 edge sync 1"); cyc("R8 edge sync 2"); cyc("R8 edge set");
      cyc("R8 edge held");
      wclr(8'h80, "R8 edge w1c");
      rxd = 1;
      repeat (4) cyc("R8 rising edge ignored");
      ren = 0; rxd = 0;
      repeat (4) cyc("R8 disabled ignored");
      rxd = 1; repeat (3) cyc("R8 settle");
      ren = 1; rxd = 0; cyc("R8 e1"); cyc("R8 e2");
      wr = 1; wd = 8'h80; cyc("R7 edge set beats clear"); quiet();
      rxd = 1; repeat (3) cyc("R8 settle");
      wclr(8'h80, "R8 clear");

      // R9 transmit word trigger
      txe = 1; bt = 1; cyc("R9 tx trigger rise"); quiet();
      repeat (5) cyc("R9 tx trigger held");
      bt = 1; cyc("R9 tx trigger fall"); quiet();
      cyc("R9 tx trigger low");

      // R11 idle trigger
      idl = 1; ot = 1; cyc("R11 idle rise"); quiet();
      repeat (3) cyc("R11 idle held");
      ot = 1; cyc("R11 idle fall"); quiet();

      // mixed sweep
      for (int i = 0; i < 48; i++) begin
         m1 = 8'(i * 3);
         m2 = 8'(i * 5);
         ot = (i % 2 == 0);
         bt = (i % 4 == 1);
         idl = (i % 7 == 3);
         send(8'(i * 15), i[0], i[1], i[2], (i % 3 != 0), "R2 R3 R4 R5 sweep");
         if (i % 5 == 0) wclr(8'(i * 37), "R6 sweep clear");
      end

      done = 1;
      @(posedge clk); #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule